// File: doc/BRIEF.md
# DDS Tuning and Phase Core

This block is the numeric heart of a direct digital synthesizer. It keeps a 48-bit phase accumulator that gains the active frequency tuning word on every system clock, so the output frequency is FTW × f_clk / 2^48. A 14-bit phase offset is added to the top of the accumulator to give the phase word that a later phase-to-amplitude stage turns into a sample. A 12-bit amplitude scale is passed alongside it.

The tuning word, phase offset, amplitude scale and a 3-bit mode code are loaded through a small address/data/write-enable port into shadow registers. They move into the active registers together, and only when a single-cycle update strobe arrives. A new tuning word never clears the accumulator, so a frequency change is phase continuous. Reset gives 0 Hz, zero phase and zero amplitude, which is the midscale level at the converter. All five mode codes and the three unused codes are stored, and every one of them runs the single-tone stepping.

Top module: `dds_tune_core`

## Requirements
- R1: While reset is low and just after it, the accumulator, phase word, amplitude and mode code are all zero, and so are every shadow and active register.
- R2: On each rising clock edge the accumulator becomes its old value plus the active tuning word, modulo 2^48. A zero tuning word holds it still.
- R3: A shadow write does not change any output until an update strobe. Outputs keep their previous frequency, offset, amplitude and mode.
- R4: An update does not reset the accumulator. At the strobe edge the accumulator still steps by the old tuning word. From the next edge on it steps by the new one, continuing from the phase it has reached.
- R5: The phase word equals accumulator bits [47:34] plus the active 14-bit offset, modulo 2^14, with no register between them.
- R6: The amplitude output equals the active 12-bit amplitude scale, which changes only at an update edge.
- R7: The mode code output shows the committed 3-bit code (000 single tone, 001 FSK, 010 ramped FSK, 011 chirp, 100 BPSK, 101 to 111 unused). For every code the accumulator steps by the single tuning word as in single tone.
- R8: Write map: address 0, 1 and 2 load tuning word bits [15:0], [31:16] and [47:32] from wr_data. Address 3 loads the offset from wr_data[13:0], address 4 loads the amplitude from wr_data[11:0], and address 5 loads the mode from wr_data[2:0]. Writes to addresses 6 and 7 are ignored.
- R9: When a write and an update fall in the same cycle, the commit takes the shadow contents from before that write. The written value waits in the shadow for the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Shadow register write enable |
| wr_addr | input | 3 | Shadow register address |
| wr_data | input | 16 | Shadow register write data |
| update | input | 1 | Single-cycle commit strobe, shadow to active |
| phase_acc | output | 48 | Current accumulator value |
| phase_word | output | 14 | Truncated phase plus offset |
| amplitude | output | 12 | Active amplitude scale |
| mode_code | output | 3 | Active mode code |

## Verification
On every cycle, the assertions check that the active registers and the mode hold steady when no strobe is present. They also check that a zero tuning word freezes the accumulator, that writes to unmapped addresses leave the shadow untouched, and that a zero offset passes the accumulator's top bits straight through. Phase continuity across tuning-word changes, the timing of a commit relative to the accumulator step, and the same-cycle write-and-update ordering can only be shown by the bench. Its reference accumulator runs next to the design through a series of tuning programs and directed corner cases.

// File: rtl/dds_pkg.sv
package dds_pkg;

   typedef enum logic [2:0] {
      TONE_SINGLE = 3'b000,
      TONE_FSK    = 3'b001,
      TONE_RFSK   = 3'b010,
      TONE_CHIRP  = 3'b011,
      TONE_BPSK   = 3'b100
   } tone_mode_e;

   localparam int MODE_W = 3;

   function automatic int words_for(input int bits, input int word_w);
      return (bits + word_w - 1) / word_w;
   endfunction

endpackage

// File: rtl/dds_shadow_regs.sv
module dds_shadow_regs
   import dds_pkg::*;
#(
   parameter int ACC_W   = 48,
   parameter int PHASE_W = 14,
   parameter int AMP_W   = 12,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               update,
   output logic [ACC_W-1:0]   ftw_act,
   output logic [PHASE_W-1:0] off_act,
   output logic [AMP_W-1:0]   amp_act,
   output logic [MODE_W-1:0]  mode_act
);

   localparam int FTW_WORDS = words_for(ACC_W, DATA_W);
   localparam int WIDE_W    = FTW_WORDS * DATA_W;
   localparam int A_OFF     = FTW_WORDS;
   localparam int A_AMP     = FTW_WORDS + 1;
   localparam int A_MODE    = FTW_WORDS + 2;

   if (A_MODE >= (1 << ADDR_W)) begin : g_bad_addr_w
      $error("ADDR_W too small for the register map");
   end
   if (DATA_W < PHASE_W || DATA_W < AMP_W || DATA_W < MODE_W) begin : g_bad_data_w
      $error("DATA_W narrower than a field");
   end

   logic [WIDE_W-1:0]  ftw_sh_wide;
   logic [PHASE_W-1:0] off_sh;
   logic [AMP_W-1:0]   amp_sh;
   logic [MODE_W-1:0]  mode_sh;

   for (genvar w = 0; w < FTW_WORDS; w++) begin : g_ftw_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ftw_sh_wide[w*DATA_W +: DATA_W] <= '0;
         else if (wr_en && (wr_addr == ADDR_W'(w)))
            ftw_sh_wide[w*DATA_W +: DATA_W] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_sh  <= '0;
         amp_sh  <= '0;
         mode_sh <= TONE_SINGLE;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(A_OFF))  off_sh  <= wr_data[PHASE_W-1:0];
         if (wr_addr == ADDR_W'(A_AMP))  amp_sh  <= wr_data[AMP_W-1:0];
         if (wr_addr == ADDR_W'(A_MODE)) mode_sh <= wr_data[MODE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ftw_act  <= '0;
         off_act  <= '0;
         amp_act  <= '0;
         mode_act <= TONE_SINGLE;
      end else if (update) begin
         ftw_act  <= ftw_sh_wide[ACC_W-1:0];
         off_act  <= off_sh;
         amp_act  <= amp_sh;
         mode_act <= mode_sh;
      end
   end

   p_hold_no_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !update |=> ($stable(ftw_act) && $stable(off_act) && $stable(amp_act)));

   p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !update |=> $stable(mode_act));

   p_unmapped_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr > ADDR_W'(A_MODE))) |=>
         ($stable(ftw_sh_wide) && $stable(off_sh) && $stable(amp_sh) && $stable(mode_sh)));

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int ACC_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] ftw_i,
   output logic [ACC_W-1:0] acc_q
);

   if (ACC_W < 2) begin : g_bad_acc_w
      $error("ACC_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_q + ftw_i;
   end

   p_zero_ftw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ftw_i == '0) |=> $stable(acc_q));

endmodule

// File: rtl/dds_phase_offset.sv
module dds_phase_offset #(
   parameter int ACC_W   = 48,
   parameter int PHASE_W = 14,
   parameter bit OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ACC_W-1:0]   acc_i,
   input  logic [PHASE_W-1:0] off_i,
   output logic [PHASE_W-1:0] phase_o
);

   if (PHASE_W > ACC_W) begin : g_bad_phase_w
      $error("PHASE_W exceeds ACC_W");
   end

   logic [PHASE_W-1:0] sum;
   assign sum = acc_i[ACC_W-1 -: PHASE_W] + off_i;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) phase_o <= '0;
         else        phase_o <= sum;
      end
   end else begin : g_comb
      assign phase_o = sum;

      p_zero_offset_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (off_i == '0) |-> (phase_o == acc_i[ACC_W-1 -: PHASE_W]));
   end

endmodule

// File: rtl/dds_tune_core.sv
module dds_tune_core
   import dds_pkg::*;
#(
   parameter int ACC_W   = 48,
   parameter int PHASE_W = 14,
   parameter int AMP_W   = 12,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 3,
   parameter bit OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               update,
   output logic [ACC_W-1:0]   phase_acc,
   output logic [PHASE_W-1:0] phase_word,
   output logic [AMP_W-1:0]   amplitude,
   output logic [MODE_W-1:0]  mode_code
);

   logic [ACC_W-1:0]   ftw_act;
   logic [PHASE_W-1:0] off_act;

   dds_shadow_regs #(
      .ACC_W(ACC_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W),
      .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .update(update),
      .ftw_act(ftw_act), .off_act(off_act),
      .amp_act(amplitude), .mode_act(mode_code)
   );

   // Every mode code, legal or not, steps the accumulator as single tone.
   dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .ftw_i(ftw_act), .acc_q(phase_acc)
   );

   dds_phase_offset #(
      .ACC_W(ACC_W), .PHASE_W(PHASE_W), .OUT_REG(OUT_REG)
   ) u_off (
      .clk(clk), .rst_n(rst_n), .acc_i(phase_acc), .off_i(off_act),
      .phase_o(phase_word)
   );

   p_amp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !update |=> $stable(amplitude));

endmodule

// File: tb/tb_dds_tune_core.sv
module tb_dds_tune_core;

   typedef struct packed {
      logic [47:0] ftw;
      logic [13:0] off;
      logic [11:0] amp;
      logic [2:0]  mode;
      logic [7:0]  run;
   } prog_t;

   localparam int NPROG = 6;
   localparam prog_t PROGS [NPROG] = '{
      '{48'h0000_1000_0000, 14'h0000, 12'h800, 3'd0, 8'd20},
      '{48'h8000_0000_0001, 14'h1234, 12'hFFF, 3'd0, 8'd10},
      '{48'hFFFF_FFFF_FFFF, 14'h3FFF, 12'h001, 3'd1, 8'd15},
      '{48'h0123_4567_89AB, 14'h2000, 12'h5A5, 3'd4, 8'd25},
      '{48'h0000_0000_0001, 14'h0000, 12'h000, 3'd7, 8'd12},
      '{48'h4000_0000_0000, 14'h0001, 12'h7FF, 3'd3, 8'd9}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        update = 1'b0;
   logic [47:0] phase_acc;
   logic [13:0] phase_word;
   logic [11:0] amplitude;
   logic [2:0]  mode_code;

   int checks = 0;
   int errors = 0;

   logic [47:0] r_acc, r_ftw, s_ftw;
   logic [13:0] r_off, s_off;
   logic [11:0] r_amp, s_amp;
   logic [2:0]  r_mode, s_mode;

   always #4 clk = ~clk;

   dds_tune_core dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .update(update), .phase_acc(phase_acc),
      .phase_word(phase_word), .amplitude(amplitude), .mode_code(mode_code)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      r_acc = '0; r_ftw = '0; s_ftw = '0;
      r_off = '0; s_off = '0; r_amp = '0; s_amp = '0;
      r_mode = '0; s_mode = '0;
   endtask

   task automatic check_all(input string tag);
      logic [13:0] ph;
      ph = r_acc[47:34] + r_off;
      check({tag, " R2 R4 accumulator"}, 64'(phase_acc), 64'(r_acc));
      check({tag, " R5 phase word"}, 64'(phase_word), 64'(ph));
      check({tag, " R6 amplitude"}, 64'(amplitude), 64'(r_amp));
      check({tag, " R7 mode code"}, 64'(mode_code), 64'(r_mode));
   endtask

   // One clock: the reference follows the requirements, then outputs are compared.
   task automatic tick(input string tag);
      logic u, w;
      logic [2:0]  a;
      logic [15:0] d;
      u = update; w = wr_en; a = wr_addr; d = wr_data;
      @(posedge clk);
      r_acc = r_acc + r_ftw;
      if (u) begin
         r_ftw = s_ftw; r_off = s_off; r_amp = s_amp; r_mode = s_mode;
      end
      if (w) begin
         case (a)
            3'd0: s_ftw[15:0]  = d;
            3'd1: s_ftw[31:16] = d;
            3'd2: s_ftw[47:32] = d;
            3'd3: s_off  = d[13:0];
            3'd4: s_amp  = d[11:0];
            3'd5: s_mode = d[2:0];
            default: ;
         endcase
      end
      @(negedge clk);
      check_all(tag);
      wr_en = 1'b0; update = 1'b0;
   endtask

   task automatic write_reg(input logic [2:0] a, input logic [15:0] d, input string tag);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick(tag);
   endtask

   task automatic strobe(input string tag);
      update = 1'b1;
      tick(tag);
   endtask

   task automatic load_prog(input prog_t p, input string tag);
      write_reg(3'd0, p.ftw[15:0], tag);
      write_reg(3'd1, p.ftw[31:16], tag);
      write_reg(3'd2, p.ftw[47:32], tag);
      write_reg(3'd3, 16'(p.off), tag);
      write_reg(3'd4, 16'(p.amp), tag);
      write_reg(3'd5, 16'(p.mode), tag);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      // R1: reset state seen while reset is held
      check_all("R1 in reset");
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) tick("R1 after reset");

      // Vector table walk: program shadow (R3: outputs unchanged meanwhile), commit, run
      for (int k = 0; k < NPROG; k++) begin
         load_prog(PROGS[k], "R3 R8 shadow load");
         strobe("R4 R7 commit");
         for (int c = 0; c < int'(PROGS[k].run); c++) tick("R2 R4 R7 run");
      end

      // R3: a complete new program without update keeps the old frequency
      load_prog('{48'h0000_0400_0000, 14'h0100, 12'h0AA, 3'd2, 8'd0}, "R3 no strobe");
      for (int i = 0; i < 8; i++) tick("R3 no strobe hold");
      check("R3 amplitude unchanged", 64'(amplitude), 64'(PROGS[NPROG-1].amp));
      strobe("R3 late commit");
      check("R3 amplitude committed", 64'(amplitude), 64'h0AA);
      for (int i = 0; i < 6; i++) tick("R4 after late commit");

      // R8: unmapped addresses have no effect after a commit
      write_reg(3'd6, 16'hFFFF, "R8 addr6");
      write_reg(3'd7, 16'h5555, "R8 addr7");
      strobe("R8 commit after unmapped");
      check("R8 amplitude after unmapped", 64'(amplitude), 64'h0AA);
      check("R8 mode after unmapped", 64'(mode_code), 64'd2);
      tick("R8 run");

      // R5 wrap: one top-bit step per cycle with offset 3FFF
      write_reg(3'd0, 16'h0000, "R5 setup");
      write_reg(3'd1, 16'h0000, "R5 setup");
      write_reg(3'd2, 16'h0004, "R5 setup");
      write_reg(3'd3, 16'h3FFF, "R5 setup");
      strobe("R5 wrap commit");
      for (int i = 0; i < 20; i++) tick("R5 wrap");

      // R9: write and update in the same cycle
      write_reg(3'd4, 16'h0123, "R9 pre");
      wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h0456; update = 1'b1;
      tick("R9 same cycle");
      check("R9 commit uses old shadow", 64'(amplitude), 64'h123);
      strobe("R9 second commit");
      check("R9 written value waits", 64'(amplitude), 64'h456);

      // R1: reset in mid-run clears everything
      tick("R1 pre reset");
      rst_n = 1'b0;
      model_clear();
      #1;
      check_all("R1 mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) tick("R1 R2 zero after reset");
      strobe("R1 shadow cleared");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule